// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block finds the integer divisor and fractional multiply/add pair that bring a UART bit clock closest to a requested baud rate. The caller supplies the input clock frequency, the target rate and an accepted error in percent, then pulses `start`. The engine tries every multiplier and add-value pair in a fixed order. For each pair it works out a rounded integer divisor, checks it against a legal range, and measures how far the resulting rate lands from the target. When the search ends it reports the best divisor, multiplier, add value and error, together with a flag that says whether that error is inside the tolerance.

All arithmetic is integer and runs through one shared restoring divider that the engine owns. An evaluation takes at most three divisions. The search stops early as soon as a candidate hits the target exactly. The result registers keep their values until the next search completes, so the caller may read them at any time after the one-cycle `done` pulse.

Top module: `baud_search`

## Requirements
- R1: After reset, `busy`, `done` and `pass` are low, `best_dl` is 0, `best_mul` is 1, `best_add` is 0 and `best_err` is 100000.
- R2: A `start` pulse while `busy` is low begins a search and raises `busy` on the next cycle. A `start` while `busy` is high is ignored, and the result is that of the search already running.
- R3: `done` is high for exactly one cycle when a search ends, with the results valid in that cycle. The result outputs change only in a cycle where `done` is high.
- R4: The working clock value is `clk_hz` divided by 16 with the remainder dropped (`clk_hz >> 4`).
- R5: The multiplier runs from 1 to 15 in the outer loop and the add value from 0 to 15 in the inner loop. For each pair, temp = (mul × clk16) / (mul + add) in integer division.
- R6: The candidate divisor is temp / baud, plus one when temp mod baud is strictly greater than baud / 2 (integer halving).
- R7: A candidate counts only when its divisor is greater than 2 and less than 2^DL_W.
- R8: The error of a counted candidate is |temp / divisor − baud|. The stored best is replaced only when this error is strictly smaller than the stored best error, so on a tie the earlier pair is kept.
- R9: The best error starts at 100000 with multiplier 1, add 0 and divisor 0. If no candidate counts, these are the values reported.
- R10: The search ends right after a candidate with zero error is recorded. No later pair is evaluated.
- R11: `pass` is high only when best_err < (baud × tol_pct) / 100, with the division in integers.
- R12: A search started with `baud` equal to 0 evaluates no pair, reports the R9 values and ends with `pass` low, with `done` two cycles after the `start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to begin a search |
| clk_hz | input | W | Input clock frequency in Hz |
| baud | input | W | Target baud rate |
| tol_pct | input | 8 | Accepted error in percent |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| pass | output | 1 | Best error is inside the tolerance |
| best_dl | output | DL_W | Best integer divisor |
| best_mul | output | 4 | Best multiplier |
| best_add | output | 4 | Best add value |
| best_err | output | max(W,17) | Best absolute rate error |

## Verification
The bench builds the engine with W = 12 and DL_W = 6. This keeps each division to twelve steps, so several full 240-pair sweeps fit in the run. The 64 limit on the divisor is low enough that ordinary targets produce candidates on both sides of the range window. With these widths the bench reaches a first-pair exact hit, targets that no pair can reach, a truncating prescale, a zero target, and tolerance values on either side of the best error. A bench model of the stated loop computes the expected results for every case.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_TEMP,
        ST_QUOT,
        ST_RATE,
        ST_NEXT,
        ST_FINISH
    } srch_state_e;

    localparam int unsigned ERR_START = 100000;
    localparam int unsigned PAIR_MAX  = 15;
    localparam int unsigned PRESCALE  = 4;

endpackage

// File: rtl/bs_divider.sv
module bs_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } dv_t;

    dv_t dv_d, dv_q;

    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        dv_d    = dv_q;
        dv_d.fin = 1'b0;
        shifted = {dv_q.rem, dv_q.quo[W-1]};
        trial   = shifted - {1'b0, dv_q.den};
        if (go) begin
            dv_d.run = 1'b1;
            dv_d.cnt = CW'(W);
            dv_d.rem = '0;
            dv_d.quo = num;
            dv_d.den = den;
        end else if (dv_q.run) begin
            if (!trial[W]) begin
                dv_d.rem = trial[W-1:0];
                dv_d.quo = {dv_q.quo[W-2:0], 1'b1};
            end else begin
                dv_d.rem = shifted[W-1:0];
                dv_d.quo = {dv_q.quo[W-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.run = 1'b0;
                dv_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign fin = dv_q.fin;
    assign quo = dv_q.quo;
    assign rem = dv_q.rem;

endmodule

// File: rtl/bs_round_check.sv
module bs_round_check #(
    parameter int W    = 32,
    parameter int DL_W = 16
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] baud,
    output logic [W-1:0] dl,
    output logic         valid
);
    localparam logic [W:0] DL_LIM = (W+1)'(1) << DL_W;

    logic round_up;

    always_comb begin
        round_up = (rem > (baud >> 1));
        dl       = quo + {{(W-1){1'b0}}, round_up};
        valid    = (dl > W'(2)) && ({1'b0, dl} < DL_LIM);
    end

endmodule

// File: rtl/bs_err_judge.sv
module bs_err_judge #(
    parameter int W  = 32,
    parameter int EW = 32
) (
    input  logic [W-1:0]  calc,
    input  logic [W-1:0]  baud,
    input  logic [EW-1:0] best_err,
    input  logic [7:0]    tol,
    output logic [EW-1:0] err,
    output logic          better,
    output logic          zero,
    output logic          ok
);
    localparam int PW = EW + 8;

    logic [W-1:0]  diff;
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    always_comb begin
        diff   = (calc >= baud) ? (calc - baud) : (baud - calc);
        err    = EW'(diff);
        better = (err < best_err);
        zero   = (diff == '0);
        lhs    = (PW'(best_err) + PW'(1)) * PW'(100);
        rhs    = PW'(baud) * PW'(tol);
        ok     = (lhs <= rhs);
    end

endmodule

// File: rtl/baud_search.sv
module baud_search
    import baud_search_pkg::*;
#(
    parameter int W    = 32,
    parameter int DL_W = 16,
    localparam int EW  = (W > 17) ? W : 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    clk_hz,
    input  logic [W-1:0]    baud,
    input  logic [7:0]      tol_pct,
    output logic            busy,
    output logic            done,
    output logic            pass,
    output logic [DL_W-1:0] best_dl,
    output logic [3:0]      best_mul,
    output logic [3:0]      best_add,
    output logic [EW-1:0]   best_err
);
    localparam logic [3:0] LAST = 4'(PAIR_MAX);

    typedef struct packed {
        srch_state_e     st;
        logic [3:0]      mul;
        logic [3:0]      add;
        logic [W-1:0]    c16;
        logic [W-1:0]    baud;
        logic [7:0]      tol;
        logic [W-1:0]    temp;
        logic            stop;
        logic            go;
        logic [W-1:0]    op_n;
        logic [W-1:0]    op_d;
        logic [EW-1:0]   b_err;
        logic [DL_W-1:0] b_dl;
        logic [3:0]      b_mul;
        logic [3:0]      b_add;
        logic [EW-1:0]   o_err;
        logic [DL_W-1:0] o_dl;
        logic [3:0]      o_mul;
        logic [3:0]      o_add;
        logic            o_pass;
        logic            done;
    } ctl_t;

    ctl_t r_d, r_q;

    logic            dv_fin;
    logic [W-1:0]    dv_quo;
    logic [W-1:0]    dv_rem;
    logic [W-1:0]    rc_dl;
    logic            rc_valid;
    logic [EW-1:0]   jd_err;
    logic            jd_better;
    logic            jd_zero;
    logic            jd_ok;
    logic [W+3:0]    prod;

    bs_divider #(.W(W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (r_q.go),
        .num  (r_q.op_n),
        .den  (r_q.op_d),
        .fin  (dv_fin),
        .quo  (dv_quo),
        .rem  (dv_rem)
    );

    bs_round_check #(.W(W), .DL_W(DL_W)) u_round (
        .quo  (dv_quo),
        .rem  (dv_rem),
        .baud (r_q.baud),
        .dl   (rc_dl),
        .valid(rc_valid)
    );

    bs_err_judge #(.W(W), .EW(EW)) u_judge (
        .calc    (dv_quo),
        .baud    (r_q.baud),
        .best_err(r_q.b_err),
        .tol     (r_q.tol),
        .err     (jd_err),
        .better  (jd_better),
        .zero    (jd_zero),
        .ok      (jd_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        prod     = (W+4)'(r_q.c16) * (W+4)'(r_q.mul);
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.c16   = clk_hz >> PRESCALE;
                    r_d.baud  = baud;
                    r_d.tol   = tol_pct;
                    r_d.mul   = 4'd1;
                    r_d.add   = 4'd0;
                    r_d.stop  = 1'b0;
                    r_d.b_err = EW'(ERR_START);
                    r_d.b_dl  = '0;
                    r_d.b_mul = 4'd1;
                    r_d.b_add = 4'd0;
                    r_d.st    = (baud == '0) ? ST_FINISH : ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                r_d.op_n = prod[W-1:0];
                r_d.op_d = W'(r_q.mul) + W'(r_q.add);
                r_d.go   = 1'b1;
                r_d.st   = ST_TEMP;
            end
            ST_TEMP: begin
                if (dv_fin) begin
                    r_d.temp = dv_quo;
                    r_d.op_n = dv_quo;
                    r_d.op_d = r_q.baud;
                    r_d.go   = 1'b1;
                    r_d.st   = ST_QUOT;
                end
            end
            ST_QUOT: begin
                if (dv_fin) begin
                    if (rc_valid) begin
                        r_d.b_dl = r_q.b_dl;
                        r_d.op_n = r_q.temp;
                        r_d.op_d = rc_dl;
                        r_d.go   = 1'b1;
                        r_d.st   = ST_RATE;
                    end else begin
                        r_d.st = ST_NEXT;
                    end
                end
            end
            ST_RATE: begin
                if (dv_fin) begin
                    if (jd_better) begin
                        r_d.b_err = jd_err;
                        r_d.b_dl  = DL_W'(r_q.op_d);
                        r_d.b_mul = r_q.mul;
                        r_d.b_add = r_q.add;
                        r_d.stop  = jd_zero;
                    end
                    r_d.st = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (r_q.stop || (r_q.mul == LAST && r_q.add == LAST)) begin
                    r_d.st = ST_FINISH;
                end else begin
                    if (r_q.add == LAST) begin
                        r_d.mul = r_q.mul + 4'd1;
                        r_d.add = 4'd0;
                    end else begin
                        r_d.add = r_q.add + 4'd1;
                    end
                    r_d.st = ST_LAUNCH;
                end
            end
            ST_FINISH: begin
                r_d.o_err  = r_q.b_err;
                r_d.o_dl   = r_q.b_dl;
                r_d.o_mul  = r_q.b_mul;
                r_d.o_add  = r_q.b_add;
                r_d.o_pass = jd_ok;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.mul   <= 4'd1;
            r_q.b_err <= EW'(ERR_START);
            r_q.b_mul <= 4'd1;
            r_q.o_err <= EW'(ERR_START);
            r_q.o_mul <= 4'd1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign pass     = r_q.o_pass;
    assign best_dl  = r_q.o_dl;
    assign best_mul = r_q.o_mul;
    assign best_add = r_q.o_add;
    assign best_err = r_q.o_err;

endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
    parameter int W    = 32,
    parameter int DL_W = 16,
    localparam int EW  = (W > 17) ? W : 17
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [W-1:0]    baud,
    input logic            busy,
    input logic            done,
    input logic            pass,
    input logic [DL_W-1:0] best_dl,
    input logic [3:0]      best_mul,
    input logic [3:0]      best_add,
    input logic [EW-1:0]   best_err
);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_dl) && $stable(best_mul) && $stable(best_add) && $stable(best_err) && $stable(pass))); // R3

    AST_MUL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_mul != 4'd0)); // R5

    AST_DL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_dl != '0) |-> (best_dl > DL_W'(2))); // R7

    AST_NO_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_dl == '0) |-> (best_err == EW'(100000) && best_mul == 4'd1 && best_add == 4'd0)); // R9

    AST_ZERO_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && baud == '0) |=> busy ##1 (done && !pass)); // R12

endmodule

bind baud_search bs_checker #(.W(W), .DL_W(DL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .baud    (baud),
    .busy    (busy),
    .done    (done),
    .pass    (pass),
    .best_dl (best_dl),
    .best_mul(best_mul),
    .best_add(best_add),
    .best_err(best_err)
);

// File: tb/baud_search_test.sv
module baud_search_test;
    localparam int  W      = 12;
    localparam int  DL_W   = 6;
    localparam int  EW     = (W > 17) ? W : 17;
    localparam time TCLK   = 10ns;
    localparam int  WDOG   = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [W-1:0]    clk_hz = '0;
    logic [W-1:0]    baud = '0;
    logic [7:0]      tol_pct = '0;
    logic            busy;
    logic            done;
    logic            pass;
    logic [DL_W-1:0] best_dl;
    logic [3:0]      best_mul;
    logic [3:0]      best_add;
    logic [EW-1:0]   best_err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit hung  = 1'b0;

    baud_search #(.W(W), .DL_W(DL_W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .clk_hz  (clk_hz),
        .baud    (baud),
        .tol_pct (tol_pct),
        .busy    (busy),
        .done    (done),
        .pass    (pass),
        .best_dl (best_dl),
        .best_mul(best_mul),
        .best_add(best_add),
        .best_err(best_err)
    );

    always #(TCLK/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input longint fclk, input longint fb, input longint tol,
                         output longint e_dl, output longint e_mul, output longint e_add,
                         output longint e_err, output longint e_ok);
        longint c16, temp, d, calc, e;
        bit stop;
        c16 = fclk / 16;
        e_dl = 0; e_mul = 1; e_add = 0; e_err = 100000;
        stop = 1'b0;
        if (fb != 0) begin
            for (int m = 1; m <= 15 && !stop; m++) begin
                for (int a = 0; a <= 15 && !stop; a++) begin
                    temp = (m * c16) / (m + a);
                    d = temp / fb;
                    if ((temp % fb) > (fb / 2)) d = d + 1;
                    if (d > 2 && d < (64'd1 << DL_W)) begin
                        calc = temp / d;
                        e = (calc > fb) ? calc - fb : fb - calc;
                        if (e < e_err) begin
                            e_err = e; e_dl = d; e_mul = m; e_add = a;
                            if (e == 0) stop = 1'b1;
                        end
                    end
                end
            end
        end
        e_ok = (e_err < (fb * tol) / 100) ? 1 : 0;
    endtask

    task automatic wait_done(input string tag);
        while (!done && !hung) begin
            @(negedge clk);
            if (cyc > WDOG) begin
                hung = 1'b1;
                chk({tag, " watchdog"}, 0, 1);
            end
        end
    endtask

    task automatic run(input string tag, input longint fclk, input longint fb,
                       input longint tol, input bit poke);
        longint e_dl, e_mul, e_add, e_err, e_ok;
        if (hung) return;
        model(fclk, fb, tol, e_dl, e_mul, e_add, e_err, e_ok);
        @(negedge clk);
        clk_hz = W'(fclk); baud = W'(fb); tol_pct = 8'(tol);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R2 busy after start"}, longint'(busy), 1);
        if (poke) begin
            for (int k = 0; k < 40; k++) @(negedge clk);
            clk_hz = W'(3200); baud = W'(25); tol_pct = 8'd90;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(tag);
        chk({tag, " R8 best_dl"},  longint'(best_dl),  e_dl);
        chk({tag, " R5 best_mul"}, longint'(best_mul), e_mul);
        chk({tag, " R5 best_add"}, longint'(best_add), e_add);
        chk({tag, " R8 best_err"}, longint'(best_err), e_err);
        chk({tag, " R11 pass"},    longint'(pass),     e_ok);
        @(negedge clk);
        chk({tag, " R3 done one cycle"}, longint'(done), 0);
        chk({tag, " R3 result held"},    longint'(best_err), e_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy",     longint'(busy), 0);
        chk("R1 done",     longint'(done), 0);
        chk("R1 pass",     longint'(pass), 0);
        chk("R1 best_dl",  longint'(best_dl), 0);
        chk("R1 best_mul", longint'(best_mul), 1);
        chk("R1 best_add", longint'(best_add), 0);
        chk("R1 best_err", longint'(best_err), 100000);
        rst_n = 1'b1;

        run("R10 exact first pair", 4000, 25, 5, 1'b0);
        chk("R10 first pair dl", longint'(best_dl), 10);
        run("R6 full sweep",        4000, 7, 10, 1'b0);
        run("R7 window edge",       4000, 3, 20, 1'b0);
        run("R12 zero baud",        4000, 0, 50, 1'b0);
        chk("R12 pass low", longint'(pass), 0);
        run("R9 nothing fits",      4095, 300, 100, 1'b0);
        chk("R9 err start", longint'(best_err), 100000);
        run("R11 tol zero",         4000, 7, 0, 1'b0);
        run("R11 tol wide",         4000, 7, 60, 1'b0);
        run("R4 prescale trunc",    3217, 11, 30, 1'b0);
        run("R2 start while busy",  4000, 7, 10, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule